// File: doc/BRIEF.md
# Single-Channel Fly-By Bus-Master Transfer Engine

This block moves a block of bytes between one peripheral and memory without the processor handling the data. The peripheral raises a service request. The engine then asks the processor for the system bus and waits for the grant. Once it holds the bus, it acknowledges the peripheral and drives the memory address. For each byte it asserts a memory strobe together with an I/O strobe of the opposite kind. The byte then passes directly over the shared data bus in one cycle and is never latched inside the engine.

Software sets three things through a small write port before arming the engine: the start address, the byte count and a control word. The control word holds the transfer direction and the strobe length. The engine advances the address by one and lowers the count by one for every byte. It gives the bus back whenever the peripheral stops requesting. When the count runs out, it stops on its own and raises a block-done flag.

Top module: `dmafly_ctrl`

## Requirements
- R1: After reset, `bus_req`, `dev_ack`, `bus_oe`, `blk_done` and `armed` are 0, `bus_addr` is 0 and all four strobes are high.
- R2: When the engine is armed with a nonzero count and `dev_req` is high, it raises `bus_req`. It drives no strobe, no `dev_ack` and no `bus_oe` while `bus_gnt` is low, and `dev_ack` is only ever high while `bus_req` is high.
- R3: Once granted, the engine drives `bus_addr` with `dev_ack` high and all strobes inactive for exactly one clock before the strobes. It keeps the same address with `dev_ack` high and strobes inactive for one clock after them. The address does not change while the strobes are active.
- R4: When control bit 1 is 1 (peripheral to memory), `io_rd_n` and `mem_wr_n` go low together. When control bit 1 is 0 (memory to peripheral), `mem_rd_n` and `io_wr_n` go low together. The other two strobes stay high.
- R5: The strobes stay active for W clocks, where W is control bits 7:4, or 2 when that field is below 2.
- R6: Byte k of a block, counting from 0, uses address start+k modulo 2^20, so the address wraps from FFFFFh to 0.
- R7: After exactly N bytes for a programmed count N, the engine drops `bus_req` and `dev_ack`, sets `blk_done` and clears `armed`.
- R8: If `dev_req` is low when a byte finishes, the engine releases `bus_req`. It requests the bus again on the next `dev_req` and continues at the next address with the remaining count.
- R9: While `dev_req` stays high, successive bytes follow without `bus_req` dropping between them.
- R10: Arming with a count of 0 sets `blk_done` and clears `armed` without raising `bus_req`.
- R11: Register writes (`cfg_sel` 0 = start address, 1 = count, 2 = control with bit 0 arm) have no effect while `bus_req` is high.
- R12: A control write clears `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | 20 | Write data |
| dev_req | input | 1 | Peripheral service request |
| dev_ack | output | 1 | Acknowledge to the peripheral during its byte |
| bus_req | output | 1 | Bus request to the processor |
| bus_gnt | input | 1 | Bus grant from the processor |
| bus_addr | output | 20 | Memory address, 0 when not owning the bus |
| bus_oe | output | 1 | Enable for external address and strobe buffers |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | I/O read strobe, active low |
| io_wr_n | output | 1 | I/O write strobe, active low |
| blk_done | output | 1 | Count exhausted |
| armed | output | 1 | Enable bit, cleared at block end |

## Verification
Some properties are checked on every cycle:
- the strobe pairing;
- `dev_ack` only appearing under `bus_req`;
- the address being stable and acknowledged one clock before the strobes and stable during them;
- the two-clock strobe minimum;
- the address step;
- registers being frozen while the bus is requested.

Other behaviour only the bench's scenarios can show:
- the exact strobe length against the control field;
- the address sequence across a wrap;
- the byte total per block;
- the end-of-block flags;
- the number of bus requests in continuous versus one-pulse-per-byte request patterns;
- the zero-count arm case.

// File: rtl/dmafly_pkg.sv
// Shared types and register encodings for the fly-by transfer engine.
// Assumes one channel; the sequencer state is shared with the top for decode.
package dmafly_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_REQ     = 3'd1,
        ST_SETUP   = 3'd2,
        ST_STROBE  = 3'd3,
        ST_HOLDOFF = 3'd4
    } dmafly_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTL_ARM_BIT = 0;
    localparam int CTL_DIR_BIT = 1;
    localparam int CTL_LEN_LSB = 4;
    localparam int MIN_STROBE  = 2;
endpackage

// File: rtl/dmafly_regs.sv
// Program registers and address/count datapath.
// Holds the start address, remaining count, direction, strobe length, enable and done flag.
// Assumes the sequencer asserts step once per finished byte and done once per block end.
// Writes are dropped while lock (bus requested) is high.
module dmafly_regs #(
    parameter int AW = 20,
    parameter int CW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] wdata,
    input  logic          lock,
    input  logic          step,
    input  logic          done,
    output logic [AW-1:0] addr,
    output logic          cnt_last,
    output logic          cnt_zero,
    output logic          en,
    output logic          dir,
    output logic [SW-1:0] wlen,
    output logic          tc
);
    import dmafly_pkg::*;

    localparam logic [SW-1:0] WMIN = SW'(MIN_STROBE);

    logic [CW-1:0] cnt;
    logic [SW-1:0] wfield;
    logic          wr_ok;

    assign wr_ok = we && !lock;

    // Start/current address: loaded by software, advanced per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (step)
            addr <= addr + 1'b1;
        else if (wr_ok && sel == SEL_ADDR)
            addr <= wdata;
    end

    // Remaining byte count: loaded by software, lowered per byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= cnt - 1'b1;
        else if (wr_ok && sel == SEL_COUNT)
            cnt <= wdata[CW-1:0];
    end

    // Control word: enable, direction and strobe length; block end clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= 1'b0;
            dir    <= 1'b0;
            wfield <= '0;
        end else if (done) begin
            en <= 1'b0;
        end else if (wr_ok && sel == SEL_CTRL) begin
            en     <= wdata[CTL_ARM_BIT];
            dir    <= wdata[CTL_DIR_BIT];
            wfield <= wdata[CTL_LEN_LSB +: SW];
        end
    end

    // Done flag: set at block end, cleared by any accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc <= 1'b0;
        else if (done)
            tc <= 1'b1;
        else if (wr_ok && sel == SEL_CTRL)
            tc <= 1'b0;
    end

    // Derived count conditions and the clamped strobe length.
    always_comb begin
        cnt_last = (cnt == CW'(1));
        cnt_zero = (cnt == '0);
        wlen     = (wfield < WMIN) ? WMIN : wfield;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> addr == AW'($past(addr) + 1'b1)); // R6
    AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!en && tc)); // R7
    AST_LOCKED_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !step && !done) |=> ($stable(addr) && $stable(cnt) && $stable(en) && $stable(dir))); // R11
endmodule

// File: rtl/dmafly_seq.sv
// Transfer sequencer: bus request, grant wait, address setup, strobe phase, address hold.
// Assumes the grant stays high until the request is dropped.
// Emits step at each byte end and done when the block finishes or is armed with a count of 0.
module dmafly_seq #(
    parameter int SW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     dev_req,
    input  logic                     bus_gnt,
    input  logic                     cnt_last,
    input  logic                     cnt_zero,
    input  logic [SW-1:0]            wlen,
    output dmafly_pkg::dmafly_state_e st,
    output logic                     step,
    output logic                     done
);
    import dmafly_pkg::*;

    dmafly_state_e st_nx;
    logic [SW-1:0] wcnt;

    // Next-state and per-byte event decode.
    always_comb begin
        st_nx = st;
        step  = 1'b0;
        done  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (en && cnt_zero)
                    done = 1'b1;
                else if (en && dev_req)
                    st_nx = ST_REQ;
            end
            ST_REQ: begin
                if (bus_gnt)
                    st_nx = ST_SETUP;
            end
            ST_SETUP:  st_nx = ST_STROBE;
            ST_STROBE: begin
                if (wcnt >= wlen)
                    st_nx = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                step = 1'b1;
                if (cnt_last) begin
                    done  = 1'b1;
                    st_nx = ST_IDLE;
                end else if (dev_req) begin
                    st_nx = ST_SETUP;
                end else begin
                    st_nx = ST_IDLE;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= st_nx;
    end

    // Strobe-length counter: counts the clocks spent in the strobe phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (st == ST_SETUP)
            wcnt <= SW'(1);
        else if (st == ST_STROBE)
            wcnt <= wcnt + 1'b1;
    end

    AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STROBE && $past(st) != ST_STROBE) |=> st == ST_STROBE); // R5
    AST_KEEP_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLDOFF && !cnt_last && dev_req) |=> st == ST_SETUP); // R9
    AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLDOFF && !dev_req) |=> st == ST_IDLE); // R8
endmodule

// File: rtl/dmafly_ctrl.sv
// Top of the single-channel fly-by transfer engine.
// Joins the register datapath and the sequencer and decodes the bus outputs.
// Address, acknowledge and strobes are driven only while the grant is high and a byte is in progress.
// Assumes external buffers use bus_oe; the data bus is never touched here.
module dmafly_ctrl #(
    parameter int AW = 20,
    parameter int CW = 16,
    parameter int SW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dev_req,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_addr,
    output logic          bus_oe,
    output logic          mem_rd_n,
    output logic          mem_wr_n,
    output logic          io_rd_n,
    output logic          io_wr_n,
    output logic          blk_done,
    output logic          armed
);
    import dmafly_pkg::*;

    dmafly_state_e st;
    logic [AW-1:0] addr;
    logic          step, done, cnt_last, cnt_zero, dir;
    logic [SW-1:0] wlen;
    logic          own, strb;

    dmafly_regs #(.AW(AW), .CW(CW), .SW(SW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .lock(bus_req), .step(step), .done(done), .addr(addr),
        .cnt_last(cnt_last), .cnt_zero(cnt_zero), .en(armed), .dir(dir),
        .wlen(wlen), .tc(blk_done)
    );

    dmafly_seq #(.SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(armed), .dev_req(dev_req), .bus_gnt(bus_gnt),
        .cnt_last(cnt_last), .cnt_zero(cnt_zero), .wlen(wlen),
        .st(st), .step(step), .done(done)
    );

    // Bus ownership and strobe-phase decode, gated by the grant.
    always_comb begin
        own  = bus_gnt && (st == ST_SETUP || st == ST_STROBE || st == ST_HOLDOFF);
        strb = bus_gnt && (st == ST_STROBE);
    end

    // Output drive: paired strobes by direction, address only while owning.
    always_comb begin
        bus_req  = (st != ST_IDLE);
        dev_ack  = own;
        bus_oe   = own;
        bus_addr = own ? addr : '0;
        mem_rd_n = !(strb && !dir);
        io_wr_n  = !(strb && !dir);
        io_rd_n  = !(strb && dir);
        mem_wr_n = !(strb && dir);
    end

    logic strb_any;
    assign strb_any = !(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);

    AST_ACK_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> bus_req); // R2
    AST_NO_GRANT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (!dev_ack && !strb_any)); // R2
    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        strb_any |-> ((!mem_wr_n == !io_rd_n) && (!mem_rd_n == !io_wr_n) && (mem_rd_n || mem_wr_n))); // R4
    AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_any && !$past(strb_any)) |-> ($past(dev_ack) && $stable(bus_addr))); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_any && $past(strb_any)) |-> $stable(bus_addr)); // R3
endmodule

// File: tb/dmafly_ctrl_test.sv
module dmafly_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [19:0] cfg_wdata = '0;
    logic        dev_req = 1'b0;
    logic        bus_gnt = 1'b0;
    logic        dev_ack, bus_req, bus_oe, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, blk_done, armed;
    logic [19:0] bus_addr;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dmafly_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .dev_req(dev_req), .dev_ack(dev_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_addr(bus_addr), .bus_oe(bus_oe), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .blk_done(blk_done), .armed(armed)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_width(input int wf);
        return (wf < 2) ? 2 : wf;
    endfunction

    function automatic logic [19:0] exp_addr(input logic [19:0] a0, input int k);
        return 20'(a0 + 20'(k));
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one block with a processor model that grants one half-cycle after the request.
    task automatic run_block(input logic [19:0] a0, input int n, input bit d, input int wf,
                             input bit pulsed, input bit poke);
        int k = 0, holds = 0, run = 0, cyc = 0, gap = 0, pk = 0;
        int ack_err = 0, pair_err = 0, setup_err = 0, stab_err = 0, addr_err = 0, wid_err = 0;
        bit prev_hold = 0, prev_strb = 0, prev_ack = 0, s;
        logic [19:0] prev_addr = '0, cur = '0;
        cfg_write(2'd0, a0);
        cfg_write(2'd1, 20'(n));
        cfg_write(2'd2, 20'((wf << 4) | (int'(d) << 1) | 1));
        dev_req = !pulsed;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            s = !(mem_rd_n && mem_wr_n && io_rd_n && io_wr_n);
            if (bus_req && !prev_hold) holds++;
            if (!bus_gnt && (dev_ack || s)) ack_err++;
            if (s) begin
                if (d ? !(!io_rd_n && !mem_wr_n && mem_rd_n && io_wr_n)
                      : !(!mem_rd_n && !io_wr_n && io_rd_n && mem_wr_n)) pair_err++;
            end
            if (s && !prev_strb) begin
                if (!(prev_ack && prev_addr == bus_addr)) setup_err++;
                if (bus_addr != exp_addr(a0, k)) begin
                    addr_err++;
                    $display("FAIL R6 byte %0d actual=%0h expected=%0h", k, bus_addr, exp_addr(a0, k));
                end
                cur = bus_addr; run = 1;
            end else if (s) begin
                run++;
                if (bus_addr != cur) stab_err++;
            end else if (prev_strb) begin
                if (run != exp_width(wf)) wid_err++;
                if (!(dev_ack && bus_addr == cur && !s)) setup_err++;
                k++;
            end
            prev_hold = bus_req; prev_strb = s; prev_ack = dev_ack && !s; prev_addr = bus_addr;
            if (k == n && !bus_req) break;
            bus_gnt = bus_req;
            if (pulsed) begin
                if (dev_req) dev_req = 1'b0;
                else if (!bus_req && k < n) begin
                    if (gap == 0) begin dev_req = 1'b1; gap = $urandom % 4; end
                    else gap--;
                end
            end
            if (poke) begin
                cfg_we = 1'b0;
                if (pk == 0 && s) begin cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 20'h12345; pk = 1; end
                else if (pk == 1) begin cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 20'd0; pk = 2; end
                else if (pk == 2) begin cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 20'h0; pk = 3; end
            end
        end
        cfg_we = 1'b0; dev_req = 1'b0;
        @(negedge clk);
        bus_gnt = 1'b0;
        check(ack_err == 0, "R2 bus quiet without grant", ack_err, 0);
        check(setup_err == 0, "R3 address setup/hold with ack", setup_err, 0);
        check(stab_err == 0, "R3 address stable under strobe", stab_err, 0);
        check(pair_err == 0, "R4 strobe pairing", pair_err, 0);
        check(wid_err == 0, "R5 strobe width", wid_err, 0);
        check(addr_err == 0, "R6 address sequence", addr_err, 0);
        check(k == n, "R7 byte total", k, n);
        check(blk_done && !armed && !bus_req && !dev_ack, "R7 end flags",
              {blk_done, armed, bus_req, dev_ack}, 4'b1000);
        if (pulsed) check(holds == n, "R8 bus released per byte", holds, n);
        else check(holds == 1, "R9 bus kept across bytes", holds, 1);
        if (poke) check(pk == 3, "R11 writes issued during transfer", pk, 3);
    endtask

    initial begin
        #(20ns * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        int hseen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!bus_req && !dev_ack && !bus_oe && !blk_done && !armed && bus_addr == 0 &&
              mem_rd_n && mem_wr_n && io_rd_n && io_wr_n, "R1 reset state",
              {bus_req, dev_ack, bus_oe, blk_done, armed}, 0);

        run_block(20'h01000, 4, 1'b1, 3, 1'b0, 1'b0);
        run_block(20'h22000, 3, 1'b0, 0, 1'b0, 1'b0);   // field below 2 clamps to 2
        run_block(20'hFFFFE, 3, 1'b1, 2, 1'b0, 1'b0);   // R6 wrap
        run_block(20'h00400, 4, 1'b0, 5, 1'b1, 1'b0);   // R8 pulsed requests
        run_block(20'h03000, 5, 1'b1, 2, 1'b0, 1'b1);   // R11 writes during transfer

        // R12 control write clears done
        cfg_write(2'd2, 20'h0);
        check(!blk_done, "R12 control write clears done", blk_done, 0);

        // R10 arm with zero count
        cfg_write(2'd1, 20'd0);
        dev_req = 1'b1;
        cfg_write(2'd2, 20'h1);
        hseen = 0;
        repeat (3) begin @(negedge clk); if (bus_req) hseen++; end
        dev_req = 1'b0;
        check(hseen == 0, "R10 no bus request on zero count", hseen, 0);
        check(blk_done && !armed, "R10 zero count ends at once", {blk_done, armed}, 2'b10);

        for (int i = 0; i < 6; i++) begin
            run_block(20'($urandom), 1 + int'($urandom % 6), 1'($urandom), int'($urandom % 6),
                      1'($urandom), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule